// File: doc/BRIEF.md
# Thread-Block Residency and Occupancy Calculator

This block answers a single question about a compute kernel launch: how many of its thread blocks can sit on one multiprocessor at once. It also derives what follows from that answer. A controller loads a launch description and pulses `start`. The description holds threads per block, total block count, registers per thread, shared-memory bytes per block and the number of multiprocessors. Some time later the block raises `done` for exactly one cycle. At that point the result outputs hold four values: the resident block count, the resident thread count, a fixed-point occupancy fraction and the number of scheduling rounds the whole launch needs.

Three resources bound residency: warp slots, the register file and shared memory. Each is handled with the allocation granularity of real hardware. Warps are counted in whole 32-thread units. Registers are granted per warp in 256-register chunks, and the warp count that the registers allow is trimmed to a multiple of 4. Shared memory is granted in 256-byte granules. Requests of zero, and requests above the per-thread or per-multiprocessor limit, follow fixed rules rather than a plain quotient. All divisions run one after another on a single shared restoring divider.

Top module: `occ_calc`

## Requirements
- R1: Warps per block are threads per block divided by 32, rounded up. The warp-slot bound is the smaller of 16 and floor(64 / warps per block). A block of zero threads gives a bound of 0.
- R2: The shared-memory bound is 16 when the request is zero and 0 when the request exceeds 49152 bytes. Otherwise the request is rounded up to a multiple of 256 and the bound is floor(49152 / rounded request).
- R3: Registers per warp are registers per thread times 32, rounded up to a multiple of 256. The warps the register file allows are floor(65536 / registers per warp), rounded down to a multiple of 4. The register bound is that warp count divided by warps per block, rounded down. A request of zero registers gives a bound of 16.
- R4: A request of more than 64 registers per thread gives a register bound of 0.
- R5: Resident blocks equal the minimum of the warp, register and shared-memory bounds. Resident threads equal resident blocks times threads per block.
- R6: Running rounds equal ceil(threads per block × block count / (resident threads × multiprocessor count)). Rounds are 0 whenever the launch is unschedulable.
- R7: `unschedulable` is 1 exactly when resident blocks are 0 or the multiprocessor count is 0.
- R8: Occupancy equals floor(resident threads × 256 / 2048). It is a 9-bit value with 8 fractional bits, so 256 means full occupancy.
- R9: Each accepted `start` produces exactly one `done` pulse, one cycle wide. The result outputs keep their values from that pulse until the next accepted `start`.
- R10: A `start` that arrives while a calculation is in progress is ignored. The launch inputs are sampled only in the cycle a `start` is accepted.
- R11: After reset, `done`, `unschedulable` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calculation when idle |
| threads_per_block | input | TPB_W (11) | Threads in each block |
| block_count | input | BLK_W (16) | Blocks in the launch |
| regs_per_thread | input | REG_W (8) | Registers each thread uses |
| smem_bytes | input | SMEM_W (17) | Shared-memory bytes per block |
| mp_count | input | MP_W (6) | Number of multiprocessors |
| done | output | 1 | One-cycle pulse when the results are valid |
| resident_blocks | output | 5 | Blocks resident per multiprocessor |
| resident_threads | output | TPB_W+5 (16) | Threads resident per multiprocessor |
| occupancy | output | 9 | Resident threads over 2048, 8 fractional bits |
| running_rounds | output | TPB_W+BLK_W (27) | Scheduling rounds for the whole launch |
| unschedulable | output | 1 | No block fits, or no multiprocessor |

## Verification
The bench targets the inputs that sit exactly on a granule or a limit.

- A 49152-byte request must still fit one block while 49153 bytes must not. A design that tested "greater or equal" would reject the first.
- A 3100-byte request must round to 3328 bytes and give 14 blocks, not 15. A design that skipped the shared-memory rounding would report 15.
- 41 registers with 672 threads must give one block, not two. A design that dropped the rounding to a multiple of 4 would report two.
- 64 registers must be accepted and 65 must yield zero blocks. A design that got the comparison wrong would either accept 65 or reject 64.
- A 2047-thread block must round up to 64 warps. A design that truncated instead would over-count residency.
- Zero registers, zero shared memory, zero blocks and zero multiprocessors each have their own rule. A design that divided by the raw value would return garbage rounds.
- The bench also sends a second `start` in the middle of a calculation. A design that restarted or queued it would return results for the wrong launch, or emit an extra `done`.

// File: rtl/occ_pkg.sv
// occ_pkg: fixed per-multiprocessor capacities, allocation granules and
// the sequencing types shared by the residency calculator.
// Assumes the granules and thread capacity are powers of two (given as log2).
package occ_pkg;

    localparam int MAX_BLK_MP     = 16;     // block slots per multiprocessor
    localparam int MAX_WARP_MP    = 64;     // warp slots per multiprocessor
    localparam int WARP_LOG2      = 5;      // 32 threads per warp
    localparam int MAX_REG_THR    = 64;     // register ceiling per thread
    localparam int REGFILE_MP     = 65536;  // registers per multiprocessor
    localparam int SMEM_MP        = 49152;  // shared-memory bytes per multiprocessor
    localparam int REG_GRAN_LOG2  = 8;      // 256-register allocation chunk per warp
    localparam int WARP_GRAN      = 4;      // warp allocation unit for registers
    localparam int SMEM_GRAN_LOG2 = 8;      // 256-byte shared-memory granule
    localparam int THR_MP_LOG2    = 11;     // 2048 resident threads at full occupancy
    localparam int OCC_FRAC       = 8;      // fractional bits of the occupancy output

    // Order of divisions; later steps read results of earlier ones.
    typedef enum logic [2:0] {
        OP_WARP  = 3'd0,
        OP_SMEM  = 3'd1,
        OP_REGW  = 3'd2,
        OP_REGB  = 3'd3,
        OP_ROUND = 3'd4,
        OP_OCC   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

endpackage

// File: rtl/occ_prep.sv
// occ_prep: combinational rounding of a latched launch description into
// the granule-aligned quantities the divider consumes, plus the flags
// for zero and oversized requests.
// Assumes WPB_W/RPW_W/SRND_W keep their default derivations.
module occ_prep
    import occ_pkg::*;
#(
    parameter int TPB_W  = 11,
    parameter int REG_W  = 8,
    parameter int SMEM_W = 17,
    parameter int WPB_W  = TPB_W - WARP_LOG2 + 1,
    parameter int RPW_W  = REG_W + WARP_LOG2 + 1,
    parameter int SRND_W = SMEM_W + 1
) (
    input  logic [TPB_W-1:0]  tpb,
    input  logic [REG_W-1:0]  regs,
    input  logic [SMEM_W-1:0] smem,
    output logic [WPB_W-1:0]  warps_pb,
    output logic [RPW_W-1:0]  regs_pw,
    output logic [SRND_W-1:0] smem_rnd,
    output logic              smem_zero,
    output logic              smem_over,
    output logic              regs_zero,
    output logic              regs_over
);

    logic [TPB_W:0]  tpb_pad;
    logic [RPW_W-1:0] reg_prod;
    logic [RPW_W-1:0] reg_pad;
    logic [SMEM_W:0] smem_pad;

    // Round threads up to whole warps.
    always_comb begin
        tpb_pad  = {1'b0, tpb} + (TPB_W+1)'((1 << WARP_LOG2) - 1);
        warps_pb = tpb_pad[TPB_W:WARP_LOG2];
    end

    // Registers per warp, rounded up to the register chunk.
    always_comb begin
        reg_prod = {1'b0, regs, {WARP_LOG2{1'b0}}};
        reg_pad  = reg_prod + RPW_W'((1 << REG_GRAN_LOG2) - 1);
        regs_pw  = {reg_pad[RPW_W-1:REG_GRAN_LOG2], {REG_GRAN_LOG2{1'b0}}};
    end

    // Shared-memory request rounded up to the granule.
    always_comb begin
        smem_pad = {1'b0, smem} + (SMEM_W+1)'((1 << SMEM_GRAN_LOG2) - 1);
        smem_rnd = {smem_pad[SMEM_W:SMEM_GRAN_LOG2], {SMEM_GRAN_LOG2{1'b0}}};
    end

    // Special-case flags for empty and oversized requests.
    always_comb begin
        smem_zero = (smem == '0);
        smem_over = (smem > SMEM_W'(SMEM_MP));
        regs_zero = (regs == '0);
        regs_over = (regs > REG_W'(MAX_REG_THR));
    end

endmodule

// File: rtl/occ_divider.sv
// occ_divider: iterative restoring unsigned divider, one quotient bit
// per cycle, W cycles per division. quo is valid in the cycle done pulses.
// Assumes den is nonzero (the caller guards it); start is ignored while busy.
module occ_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [W:0]       trial;
    logic [W:0]       diff;
    logic [W-1:0]     rem_n;
    logic [W-1:0]     quo_n;

    // One restoring step: shift in a dividend bit, subtract if it fits.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, den_q};
        if (trial >= {1'b0, den_q}) begin
            rem_n = diff[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_n = trial[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b0};
        end
    end

    // Load operands on start, iterate W times, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_n;
                quo_q <= quo_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;

endmodule

// File: rtl/occ_calc.sv
// occ_calc: sequences six divisions on one shared divider to find the
// warp, shared-memory and register bounds on resident blocks, their
// minimum, the scheduling rounds and the occupancy of a kernel launch.
// Assumes the caller holds results from the done pulse until it restarts;
// start is only honoured when idle.
module occ_calc
    import occ_pkg::*;
#(
    parameter int TPB_W  = 11,
    parameter int BLK_W  = 16,
    parameter int REG_W  = 8,
    parameter int SMEM_W = 17,
    parameter int MP_W   = 6,
    parameter int DIV_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [TPB_W-1:0]          threads_per_block,
    input  logic [BLK_W-1:0]          block_count,
    input  logic [REG_W-1:0]          regs_per_thread,
    input  logic [SMEM_W-1:0]         smem_bytes,
    input  logic [MP_W-1:0]           mp_count,
    output logic                      done,
    output logic [4:0]                resident_blocks,
    output logic [TPB_W+4:0]          resident_threads,
    output logic [OCC_FRAC:0]         occupancy,
    output logic [TPB_W+BLK_W-1:0]    running_rounds,
    output logic                      unschedulable
);

    localparam int WPB_W  = TPB_W - WARP_LOG2 + 1;
    localparam int RPW_W  = REG_W + WARP_LOG2 + 1;
    localparam int SRND_W = SMEM_W + 1;
    localparam int RB_W   = $clog2(MAX_BLK_MP + 1);
    localparam int RT_W   = TPB_W + RB_W;
    localparam int OCC_W  = OCC_FRAC + 1;
    localparam int TOT_W  = TPB_W + BLK_W;
    localparam int DEN_W  = RT_W + MP_W;

    st_e               state_q;
    op_e               op_q;
    logic [TPB_W-1:0]  l_tpb;
    logic [BLK_W-1:0]  l_blk;
    logic [REG_W-1:0]  l_regs;
    logic [SMEM_W-1:0] l_smem;
    logic [MP_W-1:0]   l_mp;
    logic [RB_W-1:0]   lim_w;
    logic [RB_W-1:0]   lim_s;
    logic [RB_W-1:0]   lim_r;
    logic [DIV_W-1:0]  reg_warps;

    logic [WPB_W-1:0]  warps_pb;
    logic [RPW_W-1:0]  regs_pw;
    logic [SRND_W-1:0] smem_rnd;
    logic              smem_zero, smem_over, regs_zero, regs_over;

    logic [RB_W-1:0]   resident;
    logic [RT_W-1:0]   res_thr;
    logic [TOT_W-1:0]  total;
    logic [DEN_W-1:0]  den_round;
    logic              unsched_c;

    logic              div_start;
    logic              div_done;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic [DIV_W-1:0]  div_raw_den;
    logic [DIV_W-1:0]  div_quo;

    // Clamp a quotient to the block-slot ceiling.
    function automatic logic [RB_W-1:0] sat_blk(input logic [DIV_W-1:0] q);
        return (q >= DIV_W'(MAX_BLK_MP)) ? RB_W'(MAX_BLK_MP) : q[RB_W-1:0];
    endfunction

    occ_prep #(
        .TPB_W (TPB_W),
        .REG_W (REG_W),
        .SMEM_W(SMEM_W),
        .WPB_W (WPB_W),
        .RPW_W (RPW_W),
        .SRND_W(SRND_W)
    ) u_prep (
        .tpb      (l_tpb),
        .regs     (l_regs),
        .smem     (l_smem),
        .warps_pb (warps_pb),
        .regs_pw  (regs_pw),
        .smem_rnd (smem_rnd),
        .smem_zero(smem_zero),
        .smem_over(smem_over),
        .regs_zero(regs_zero),
        .regs_over(regs_over)
    );

    occ_divider #(
        .W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    // Minimum of the three bounds and the quantities derived from it.
    always_comb begin
        resident = lim_w;
        if (lim_s < resident) resident = lim_s;
        if (lim_r < resident) resident = lim_r;
        res_thr   = {{TPB_W{1'b0}}, resident} * {{RB_W{1'b0}}, l_tpb};
        total     = {{BLK_W{1'b0}}, l_tpb} * {{TPB_W{1'b0}}, l_blk};
        den_round = {{MP_W{1'b0}}, res_thr} * {{RT_W{1'b0}}, l_mp};
        unsched_c = (resident == '0) || (l_mp == '0);
    end

    // Divider operands for the current step, with a zero-divisor guard.
    always_comb begin
        div_start = (state_q == ST_ISSUE);
        case (op_q)
            OP_WARP: begin
                div_num     = DIV_W'(MAX_WARP_MP);
                div_raw_den = DIV_W'(warps_pb);
            end
            OP_SMEM: begin
                div_num     = DIV_W'(SMEM_MP);
                div_raw_den = DIV_W'(smem_rnd);
            end
            OP_REGW: begin
                div_num     = DIV_W'(REGFILE_MP);
                div_raw_den = DIV_W'(regs_pw);
            end
            OP_REGB: begin
                div_num     = reg_warps;
                div_raw_den = DIV_W'(warps_pb);
            end
            OP_ROUND: begin
                div_num     = DIV_W'(total) + DIV_W'(den_round) - DIV_W'(1);
                div_raw_den = DIV_W'(den_round);
            end
            OP_OCC: begin
                div_num     = DIV_W'({res_thr, {OCC_FRAC{1'b0}}});
                div_raw_den = DIV_W'(1 << THR_MP_LOG2);
            end
            default: begin
                div_num     = '0;
                div_raw_den = DIV_W'(1);
            end
        endcase
        div_den = (div_raw_den == '0) ? DIV_W'(1) : div_raw_den;
    end

    // Sequencer: latch the launch, run each division, commit each result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= ST_IDLE;
            op_q             <= OP_WARP;
            l_tpb            <= '0;
            l_blk            <= '0;
            l_regs           <= '0;
            l_smem           <= '0;
            l_mp             <= '0;
            lim_w            <= '0;
            lim_s            <= '0;
            lim_r            <= '0;
            reg_warps        <= '0;
            done             <= 1'b0;
            resident_blocks  <= '0;
            resident_threads <= '0;
            occupancy        <= '0;
            running_rounds   <= '0;
            unschedulable    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        l_tpb   <= threads_per_block;
                        l_blk   <= block_count;
                        l_regs  <= regs_per_thread;
                        l_smem  <= smem_bytes;
                        l_mp    <= mp_count;
                        op_q    <= OP_WARP;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (div_done) begin
                        case (op_q)
                            OP_WARP:  lim_w <= (warps_pb == '0) ? '0 : sat_blk(div_quo);
                            OP_SMEM:  lim_s <= smem_zero ? RB_W'(MAX_BLK_MP) :
                                               smem_over ? '0 : sat_blk(div_quo);
                            OP_REGW:  reg_warps <= div_quo & ~DIV_W'(WARP_GRAN - 1);
                            OP_REGB:  lim_r <= regs_over ? '0 :
                                               regs_zero ? RB_W'(MAX_BLK_MP) :
                                               (warps_pb == '0) ? '0 : sat_blk(div_quo);
                            OP_ROUND: begin
                                resident_blocks  <= resident;
                                resident_threads <= res_thr;
                                unschedulable    <= unsched_c;
                                running_rounds   <= unsched_c ? '0 : div_quo[TOT_W-1:0];
                            end
                            OP_OCC:   occupancy <= div_quo[OCC_W-1:0];
                            default:  ;
                        endcase
                        if (op_q == OP_OCC) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            op_q    <= op_e'(op_q + 3'd1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/occ_calc_chk.sv
// occ_calc_chk: protocol and result properties for occ_calc, using its
// own record of which start was accepted and the launch captured then.
// Assumes it is attached to occ_calc by the bind at the end of this file.
module occ_calc_chk
    import occ_pkg::*;
#(
    parameter int TPB_W  = 11,
    parameter int BLK_W  = 16,
    parameter int REG_W  = 8,
    parameter int SMEM_W = 17,
    parameter int MP_W   = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [TPB_W-1:0]       threads_per_block,
    input logic [REG_W-1:0]       regs_per_thread,
    input logic [SMEM_W-1:0]      smem_bytes,
    input logic [MP_W-1:0]        mp_count,
    input logic                   done,
    input logic [4:0]             resident_blocks,
    input logic [TPB_W+4:0]       resident_threads,
    input logic [OCC_FRAC:0]      occupancy,
    input logic [TPB_W+BLK_W-1:0] running_rounds,
    input logic                   unschedulable
);

    localparam int WPB_W = TPB_W - WARP_LOG2 + 1;
    localparam int PRD_W = 5 + WPB_W;

    logic              busy_q;
    logic [TPB_W-1:0]  cap_tpb;
    logic [REG_W-1:0]  cap_regs;
    logic [SMEM_W-1:0] cap_smem;
    logic [MP_W-1:0]   cap_mp;
    logic [TPB_W:0]    cap_pad;
    logic [WPB_W-1:0]  cap_warps;
    logic [PRD_W-1:0]  warp_use;
    logic [TPB_W+4:0]  thr_expect;

    // Track an accepted start and capture the launch it carried.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cap_tpb  <= '0;
            cap_regs <= '0;
            cap_smem <= '0;
            cap_mp   <= '0;
        end else if (start && (!busy_q || done)) begin
            busy_q   <= 1'b1;
            cap_tpb  <= threads_per_block;
            cap_regs <= regs_per_thread;
            cap_smem <= smem_bytes;
            cap_mp   <= mp_count;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // Warp slots that the reported residency would consume.
    always_comb begin
        cap_pad    = {1'b0, cap_tpb} + (TPB_W+1)'((1 << WARP_LOG2) - 1);
        cap_warps  = cap_pad[TPB_W:WARP_LOG2];
        warp_use   = {{WPB_W{1'b0}}, resident_blocks} * {5'b0, cap_warps};
        thr_expect = {{TPB_W{1'b0}}, resident_blocks} * {5'b0, cap_tpb};
    end

    assert_warp_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (warp_use <= PRD_W'(MAX_WARP_MP)));

    assert_smem_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_smem > SMEM_W'(SMEM_MP))) |-> (resident_blocks == 5'd0));

    assert_regs_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_regs > REG_W'(MAX_REG_THR))) |-> (resident_blocks == 5'd0));

    assert_threads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resident_threads == thr_expect));

    assert_rounds_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unschedulable) |-> (running_rounds == '0));

    assert_unsched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (unschedulable == ((resident_blocks == 5'd0) || (cap_mp == '0))));

    assert_occ_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (occupancy <= (OCC_FRAC+1)'(1 << OCC_FRAC)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> ($stable(resident_blocks) && $stable(resident_threads) &&
                                 $stable(occupancy) && $stable(running_rounds) &&
                                 $stable(unschedulable)));

    assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !done);

endmodule

bind occ_calc occ_calc_chk #(
    .TPB_W (TPB_W),
    .BLK_W (BLK_W),
    .REG_W (REG_W),
    .SMEM_W(SMEM_W),
    .MP_W  (MP_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (start),
    .threads_per_block(threads_per_block),
    .regs_per_thread  (regs_per_thread),
    .smem_bytes       (smem_bytes),
    .mp_count         (mp_count),
    .done             (done),
    .resident_blocks  (resident_blocks),
    .resident_threads (resident_threads),
    .occupancy        (occupancy),
    .running_rounds   (running_rounds),
    .unschedulable    (unschedulable)
);

// File: tb/occ_calc_tb.sv
// occ_calc_tb: directed corner cases plus seeded random launches, each
// compared with a reference model written from the requirements.
module occ_calc_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [10:0] tpb_i;
    logic [15:0] blk_i;
    logic [7:0]  regs_i;
    logic [16:0] smem_i;
    logic [5:0]  mp_i;
    logic        done;
    logic [4:0]  res_blk;
    logic [15:0] res_thr;
    logic [8:0]  occ;
    logic [26:0] rounds;
    logic        unsched;

    int errors = 0;
    int checks = 0;

    occ_calc u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .threads_per_block(tpb_i),
        .block_count      (blk_i),
        .regs_per_thread  (regs_i),
        .smem_bytes       (smem_i),
        .mp_count         (mp_i),
        .done             (done),
        .resident_blocks  (res_blk),
        .resident_threads (res_thr),
        .occupancy        (occ),
        .running_rounds   (rounds),
        .unschedulable    (unsched)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint min2(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    // Reference model written from R1..R8.
    task automatic ref_model(input longint tpb, blk, regs, smem, mp,
                             output longint rb, rt, oc, rr, un);
        longint w, lw, ls, lr, rpw, wr;
        w  = (tpb + 31) / 32;
        lw = (w == 0) ? 0 : min2(16, 64 / w);
        if (smem == 0)          ls = 16;
        else if (smem > 49152)  ls = 0;
        else                    ls = 49152 / (((smem + 255) / 256) * 256);
        if (regs > 64)          lr = 0;
        else if (regs == 0)     lr = 16;
        else begin
            rpw = ((regs * 32 + 255) / 256) * 256;
            wr  = ((65536 / rpw) / 4) * 4;
            lr  = (w == 0) ? 0 : wr / w;
        end
        rb = min2(lw, min2(ls, lr));
        rt = rb * tpb;
        un = (rb == 0 || mp == 0) ? 1 : 0;
        rr = un ? 0 : (tpb * blk + rt * mp - 1) / (rt * mp);
        oc = rt * 256 / 2048;
    endtask

    task automatic drive(input int tpb, blk, regs, smem, mp);
        tpb_i  = 11'(tpb);
        blk_i  = 16'(blk);
        regs_i = 8'(regs);
        smem_i = 17'(smem);
        mp_i   = 6'(mp);
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ok = done;
        if (!ok) begin
            checks++;
            errors++;
            $display("FAIL R9 done timeout: actual=0 expected=1");
        end
    endtask

    task automatic compare(input string tag, input int tpb, blk, regs, smem, mp);
        longint rb, rt, oc, rr, un;
        ref_model(tpb, blk, regs, smem, mp, rb, rt, oc, rr, un);
        check(tag,  "resident_blocks",  res_blk, rb);
        check("R5", "resident_threads", res_thr, rt);
        check("R6", "running_rounds",   rounds,  rr);
        check("R7", "unschedulable",    unsched, un);
        check("R8", "occupancy",        occ,     oc);
    endtask

    task automatic run_case(input string tag, input int tpb, blk, regs, smem, mp);
        bit ok;
        @(negedge clk);
        drive(tpb, blk, regs, smem, mp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (ok) begin
            compare(tag, tpb, blk, regs, smem, mp);
            @(negedge clk);
            check("R9", "done width", done, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        start = 1'b0;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "done",            done,    0);
        check("R11", "resident_blocks", res_blk, 0);
        check("R11", "running_rounds",  rounds,  0);
        check("R11", "occupancy",       occ,     0);
        check("R11", "unschedulable",   unsched, 0);
        rst_n = 1'b1;

        run_case("R1", 1024, 8, 11, 0, 8);        // warp bound 2
        run_case("R1", 2047, 10, 8, 0, 4);        // 64 warps, bound 1
        run_case("R3", 256, 100, 44, 0, 8);       // register bound 5
        run_case("R3", 672, 50, 41, 0, 2);        // round to 4 warps gives 1
        run_case("R3", 128, 9, 0, 0, 3);          // zero registers, no limit
        run_case("R2", 256, 40, 44, 24576, 8);    // shared memory bound 2
        run_case("R2", 32, 500, 8, 3100, 1);      // granule rounding gives 14
        run_case("R2", 64, 7, 8, 49152, 2);       // exactly full, bound 1
        run_case("R2", 64, 7, 8, 49153, 2);       // oversized, bound 0
        run_case("R4", 32, 5, 64, 0, 2);          // 64 registers accepted
        run_case("R4", 32, 5, 65, 0, 2);          // 65 registers rejected
        run_case("R7", 256, 30, 16, 0, 0);        // no multiprocessor
        run_case("R6", 256, 0, 16, 0, 4);         // zero blocks, zero rounds
        run_case("R6", 96, 65535, 20, 1000, 63);  // large launch

        // R10: a start during a calculation is ignored
        @(negedge clk);
        drive(256, 100, 44, 0, 8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        drive(1024, 10, 11, 0, 4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (ok) begin
            compare("R10", 256, 100, 44, 0, 8);
            begin
                int extra = 0;
                for (int i = 0; i < 300; i++) begin
                    @(negedge clk);
                    if (done) extra++;
                end
                check("R10", "extra done pulses", extra, 0);
            end
        end

        // R9: results held while idle despite input changes
        run_case("R5", 192, 77, 30, 5000, 5);
        begin
            logic [4:0] h_blk;
            logic [26:0] h_rr;
            logic [8:0] h_occ;
            h_blk = res_blk;
            h_rr  = rounds;
            h_occ = occ;
            drive(1, 1, 99, 60000, 0);
            repeat (10) @(negedge clk);
            check("R9", "held resident_blocks", res_blk, h_blk);
            check("R9", "held running_rounds",  rounds,  h_rr);
            check("R9", "held occupancy",       occ,     h_occ);
        end

        // Seeded random launches
        for (int k = 0; k < 200; k++) begin
            int tpb, blk, regs, smem, mp, sel;
            tpb = int'($urandom_range(1, 1024));
            if ($urandom_range(0, 9) == 0) tpb = int'($urandom_range(0, 2047));
            blk  = int'($urandom_range(0, 65535));
            regs = int'($urandom_range(0, 72));
            sel  = int'($urandom_range(0, 3));
            case (sel)
                0:       smem = 0;
                1:       smem = int'($urandom_range(1, 4096));
                2:       smem = int'($urandom_range(1, 49152));
                default: smem = int'($urandom_range(0, 60000));
            endcase
            mp = int'($urandom_range(0, 15));
            run_case("R5", tpb, blk, regs, smem, mp);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule